// File: doc/BRIEF.md
# Pixel Clock Parameter Search Engine

This block turns a requested pixel period, given in picoseconds, into the three settings of a frequency synthesizer: a multiplier k, a divider n and a post-divider shift p. The synthesizer scales a fixed base constant of 256016, so the block looks for the k whose product with the base divides most evenly by the period scaled by the post-divider.

A single start pulse launches a search. The block clamps short periods, rejects long ones, picks the post-divider, then walks k from 1 to 31. For each k a restoring divider produces the quotient and the remainder over several cycles. The best candidate so far is kept. When the walk ends, the block raises a done flag and presents either the winning parameters or an error. Sending the parameters to the synthesizer is left to other logic.

Top module: `pclk_param_search`

## Requirements
- R1: A period (after clamping) greater than 2048128 (eight times the base) is rejected: done rises 2 cycles after the accepted start, with err = 1 and k, n and p all zero.
- R2: A period below 5000 is treated exactly as 5000, giving the same outputs and timing.
- R3: The post-divider p is 3 when sixteen times the period is less than 256016 and 2 otherwise; the scaled period l is the period shifted left by p.
- R4: For each k from 1 to 31, with n = (256016·k) / l and rem = (256016·k) mod l, a candidate is taken only if n is nonzero, n < 128, and rem is less than the best remainder so far (which starts at l); kOut (5 bits) and nOut (7 bits) report the last candidate taken.
- R5: On equal remainders the smaller k is kept, because the comparison is strict.
- R6: When no k yields a candidate, done rises with err = 1 and k, n and p all zero.
- R7: For an in-range period, done rises exactly 2 + 31·(DIV_W + 2) cycles after the clock edge that accepts start (808 cycles with DIV_W = 24); done falls at the edge that accepts the next start and stays high until then.
- R8: A start pulse that arrives while a search is running is ignored: the running search ends on its own schedule with the results of its own period.
- R9: err, kOut, nOut and pOut change only at the edge where done rises, and hold between searches.
- R10: After reset, done, err, kOut, nOut and pOut are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches a search when idle |
| periodPs | input | PER_W (24) | Requested pixel period in picoseconds |
| done | output | 1 | High from the end of a search until the next accepted start |
| err | output | 1 | The last search found no valid settings |
| kOut | output | 5 | Chosen multiplier |
| nOut | output | 7 | Chosen divider |
| pOut | output | 2 | Chosen post-divider shift |

## Verification
A rejected period must show done exactly two cycles after the accepting edge, and an in-range one exactly 2 + 31·(DIV_W + 2) cycles after it, including searches that end in a no-candidate error. The bench drives start half a cycle ahead of the accepting edge, then counts rising edges and samples done on every falling edge, so it records the exact cycle of completion and compares it with the count due. The results are read in that same half cycle, and a check one half cycle after the accepting edge confirms that done has already dropped.

// File: rtl/pclk_search_pkg.sv
package pclk_search_pkg;

  // Strobes from the sequencer to the datapath, one per datapath action
  typedef struct packed {
    logic capture;  // latch the clamped period
    logic prep;     // latch post-divider, scaled period, reset best tracking
    logic load;     // load dividend for the current k
    logic step;     // one restoring divide step
    logic eval;     // compare the finished quotient/remainder with the best
    logic finish;   // publish results
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_LOAD,
    ST_DIV,
    ST_EVAL,
    ST_FIN
  } state_t;

endpackage

// File: rtl/pclk_search_ctrl.sv
module pclk_search_ctrl
  import pclk_search_pkg::*;
#(
  parameter int DIV_W = 24,
  parameter int K_MAX = 31,
  parameter int K_W   = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           rangeBad,
  output strobe_t        stb,
  output logic [K_W-1:0] kCur,
  output logic           busy,
  output logic           done
);

  localparam int CNT_W = $clog2(DIV_W);

  state_t             state;
  logic [CNT_W-1:0]   bitCnt;

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: stb.capture = start;
      ST_PREP: stb.prep    = 1'b1;
      ST_LOAD: stb.load    = 1'b1;
      ST_DIV:  stb.step    = 1'b1;
      ST_EVAL: stb.eval    = 1'b1;
      ST_FIN:  stb.finish  = 1'b1;
      default: stb         = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kCur   <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          // a start while busy never reaches this branch (R8)
          if (start) begin
            done  <= 1'b0;
            state <= ST_PREP;
          end
        end
        ST_PREP: begin
          kCur  <= K_W'(1);
          state <= rangeBad ? ST_FIN : ST_LOAD;  // R1 short path
        end
        ST_LOAD: begin
          bitCnt <= CNT_W'(DIV_W - 1);
          state  <= ST_DIV;
        end
        ST_DIV: begin
          if (bitCnt == '0) state <= ST_EVAL;
          else              bitCnt <= bitCnt - CNT_W'(1);
        end
        ST_EVAL: begin
          if (kCur == K_W'(K_MAX)) begin
            state <= ST_FIN;
          end else begin
            kCur  <= kCur + K_W'(1);
            state <= ST_LOAD;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;  // R7
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pclk_search_dp.sv
module pclk_search_dp
  import pclk_search_pkg::*;
#(
  parameter int PER_W   = 24,
  parameter int DIV_W   = 24,
  parameter int BASE    = 256016,
  parameter int CLK_MIN = 5000,
  parameter int N_LIMIT = 128,
  parameter int K_W     = 5,
  parameter int N_W     = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [K_W-1:0]   kCur,
  input  logic [PER_W-1:0] periodPs,
  output logic             rangeBad,
  output logic             err,
  output logic [K_W-1:0]   kOut,
  output logic [N_W-1:0]   nOut,
  output logic [1:0]       pOut
);

  localparam int EXT_W = PER_W + 5;
  localparam logic [EXT_W-1:0] LIMIT_HI = EXT_W'(BASE) << 3;
  localparam logic [EXT_W-1:0] BASE_EXT = EXT_W'(BASE);

  logic [PER_W-1:0] perReg;
  logic [EXT_W-1:0] perExt;
  logic [1:0]       pSel;
  logic [DIV_W-1:0] lVal;

  logic [DIV_W-1:0] lReg;
  logic [1:0]       pReg;

  // divider state
  logic [DIV_W-1:0] dvd;
  logic [DIV_W-1:0] remAcc;
  logic [DIV_W-1:0] quo;
  logic [DIV_W:0]   trial;
  logic [DIV_W-1:0] mVal;

  // best candidate tracking
  logic [DIV_W-1:0] bestRem;
  logic [K_W-1:0]   bestK;
  logic [N_W-1:0]   bestN;
  logic             found;
  logic             candOk;

  // range check and post-divider choice on the clamped period (R1, R3)
  assign perExt   = EXT_W'(perReg);
  assign rangeBad = perExt > LIMIT_HI;
  assign pSel     = ((perExt << 4) < BASE_EXT) ? 2'd3 : 2'd2;
  assign lVal     = DIV_W'(perExt << pSel);

  assign mVal  = DIV_W'(BASE) * DIV_W'(kCur);
  assign trial = {remAcc, dvd[DIV_W-1]} - {1'b0, lReg};

  // candidate rule: nonzero, below limit, strictly better (R4, R5)
  assign candOk = (quo != '0) && (quo < DIV_W'(N_LIMIT)) && (remAcc < bestRem);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perReg <= '0;
    end else if (stb.capture) begin
      perReg <= (periodPs < PER_W'(CLK_MIN)) ? PER_W'(CLK_MIN) : periodPs;  // R2
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lReg    <= '0;
      pReg    <= '0;
      bestRem <= '0;
      bestK   <= '0;
      bestN   <= '0;
      found   <= 1'b0;
    end else if (stb.prep) begin
      lReg    <= lVal;
      pReg    <= pSel;
      bestRem <= lVal;
      bestK   <= '0;
      bestN   <= '0;
      found   <= 1'b0;
    end else if (stb.eval && candOk) begin
      bestRem <= remAcc;
      bestK   <= kCur;
      bestN   <= N_W'(quo);
      found   <= 1'b1;
    end
  end

  // restoring shift-subtract divider, one quotient bit per step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvd    <= '0;
      remAcc <= '0;
      quo    <= '0;
    end else if (stb.load) begin
      dvd    <= mVal;
      remAcc <= '0;
      quo    <= '0;
    end else if (stb.step) begin
      dvd <= {dvd[DIV_W-2:0], 1'b0};
      if (!trial[DIV_W]) begin
        remAcc <= trial[DIV_W-1:0];
        quo    <= {quo[DIV_W-2:0], 1'b1};
      end else begin
        remAcc <= {remAcc[DIV_W-2:0], dvd[DIV_W-1]};
        quo    <= {quo[DIV_W-2:0], 1'b0};
      end
    end
  end

  // published results, updated only at completion (R6, R9, R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      err  <= 1'b0;
      kOut <= '0;
      nOut <= '0;
      pOut <= '0;
    end else if (stb.finish) begin
      if (rangeBad || !found) begin
        err  <= 1'b1;
        kOut <= '0;
        nOut <= '0;
        pOut <= '0;
      end else begin
        err  <= 1'b0;
        kOut <= bestK;
        nOut <= bestN;
        pOut <= pReg;
      end
    end
  end

endmodule

// File: rtl/pclk_param_search.sv
module pclk_param_search
  import pclk_search_pkg::*;
#(
  parameter int PER_W   = 24,
  parameter int DIV_W   = 24,
  parameter int BASE    = 256016,
  parameter int CLK_MIN = 5000,
  parameter int K_MAX   = 31,
  parameter int N_LIMIT = 128,
  parameter int K_W     = $clog2(K_MAX + 1),
  parameter int N_W     = $clog2(N_LIMIT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PER_W-1:0] periodPs,
  output logic             done,
  output logic             err,
  output logic [K_W-1:0]   kOut,
  output logic [N_W-1:0]   nOut,
  output logic [1:0]       pOut
);

  strobe_t        stb;
  logic [K_W-1:0] kCur;
  logic           rangeBad;
  logic           busy;

  pclk_search_ctrl #(
    .DIV_W (DIV_W),
    .K_MAX (K_MAX),
    .K_W   (K_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rangeBad (rangeBad),
    .stb      (stb),
    .kCur     (kCur),
    .busy     (busy),
    .done     (done)
  );

  pclk_search_dp #(
    .PER_W   (PER_W),
    .DIV_W   (DIV_W),
    .BASE    (BASE),
    .CLK_MIN (CLK_MIN),
    .N_LIMIT (N_LIMIT),
    .K_W     (K_W),
    .N_W     (N_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .kCur     (kCur),
    .periodPs (periodPs),
    .rangeBad (rangeBad),
    .err      (err),
    .kOut     (kOut),
    .nOut     (nOut),
    .pOut     (pOut)
  );

endmodule

// File: rtl/pclk_search_checker.sv
module pclk_search_checker #(
  parameter int K_W = 5,
  parameter int N_W = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [K_W-1:0] kOut,
  input logic [N_W-1:0] nOut,
  input logic [1:0]     pOut
);

  AST_ERR_ZERO_OUTS: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (kOut == '0 && nOut == '0 && pOut == 2'd0)); // R6

  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (done && !err) |-> (kOut != '0 && nOut != '0 && pOut[1])); // R4

  AST_OUTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> $stable({err, kOut, nOut, pOut})); // R9

  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R7

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R7

  AST_DONE_DROP_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(start)); // R8

endmodule

bind pclk_param_search pclk_search_checker #(
  .K_W (K_W),
  .N_W (N_W)
) i_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .kOut  (kOut),
  .nOut  (nOut),
  .pOut  (pOut)
);

// File: tb/test_pclk_param_search.sv
`timescale 1ns/1ps
module test_pclk_param_search;

  localparam int PER_W  = 24;
  localparam int DIV_W  = 24;
  localparam longint BASE = 256016;
  localparam int LAT_OK  = 2 + 31 * (DIV_W + 2);
  localparam int LAT_ERR = 2;

  typedef struct packed {
    logic [23:0] per;
    logic        bad;
    logic [1:0]  pExp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{24'd5000,    1'b0, 2'd3},
    '{24'd1200,    1'b0, 2'd3},
    '{24'd16000,   1'b0, 2'd3},
    '{24'd16001,   1'b0, 2'd2},
    '{24'd39721,   1'b0, 2'd2},
    '{24'd64004,   1'b0, 2'd2},
    '{24'd100000,  1'b0, 2'd2},
    '{24'd1984124, 1'b0, 2'd2},
    '{24'd1984125, 1'b1, 2'd0},
    '{24'd2048128, 1'b1, 2'd0},
    '{24'd2048129, 1'b1, 2'd0},
    '{24'd9000000, 1'b1, 2'd0}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [PER_W-1:0] periodPs = '0;
  logic             done;
  logic             err;
  logic [4:0]       kOut;
  logic [6:0]       nOut;
  logic [1:0]       pOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pclk_param_search #(.PER_W(PER_W), .DIV_W(DIV_W)) i_pclk_param_search (
    .clk(clk), .rstN(rstN), .start(start), .periodPs(periodPs),
    .done(done), .err(err), .kOut(kOut), .nOut(nOut), .pOut(pOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected results from the requirements
  task automatic refModel(input longint perIn, output logic e, output int k,
                          output int n, output int p, output int lat);
    longint per, l, best, m, q, r;
    per = (perIn < 5000) ? 5000 : perIn;          // R2
    k = 0; n = 0; p = 0; e = 1'b0;
    if (per > BASE * 8) begin                     // R1
      e = 1'b1; lat = LAT_ERR;
      return;
    end
    lat = LAT_OK;
    p = (per * 16 < BASE) ? 3 : 2;                // R3
    l = per << p;
    best = l;
    for (int kk = 1; kk <= 31; kk++) begin        // R4, R5
      m = BASE * kk;
      q = m / l;
      r = m % l;
      if (q != 0 && q < 128 && r < best) begin
        best = r; k = kk; n = int'(q);
      end
    end
    if (k == 0) begin                             // R6
      e = 1'b1; p = 0; n = 0;
    end
  endtask

  task automatic runSearch(input logic [23:0] per, input int interruptAt,
                           input logic [23:0] altPer, output int lat);
    @(negedge clk);
    start = 1'b1;
    periodPs = per;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7", "done cleared after accepted start", done, 0);
    lat = 0;
    while (!done && lat < 3000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (lat == interruptAt) begin
        start = 1'b1;
        periodPs = altPer;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  task automatic checkResult(input logic [23:0] per, input string tag, input int lat);
    logic e; int k, n, p, lx;
    refModel(per, e, k, n, p, lx);
    check(lat == lx, "R7", {tag, " latency"}, lat, lx);
    check(err == e, e ? "R6" : "R4", {tag, " err"}, err, e);
    check(kOut == k, "R4", {tag, " k"}, kOut, k);
    check(nOut == n, "R4", {tag, " n"}, nOut, n);
    check(pOut == p, "R3", {tag, " p"}, pOut, p);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [4:0] k5; logic [6:0] n5; logic [1:0] p5; logic e5;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(done == 0, "R10", "done after reset", done, 0);
    check(err == 0, "R10", "err after reset", err, 0);
    check({kOut, nOut, pOut} == '0, "R10", "k/n/p after reset", {kOut, nOut, pOut}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      runSearch(VECS[i].per, -1, '0, lat);
      checkResult(VECS[i].per, $sformatf("vec%0d", i), lat);
      check(err == VECS[i].bad, VECS[i].bad ? "R6" : "R1", "table err", err, VECS[i].bad);
      check(pOut == VECS[i].pExp, "R3", "table p", pOut, VECS[i].pExp);
    end

    // R1: just above eight times the base, short timing and zero outputs
    runSearch(24'd2048129, -1, '0, lat);
    check(lat == LAT_ERR, "R1", "range reject latency", lat, LAT_ERR);
    check(err == 1, "R1", "range reject err", err, 1);
    check({kOut, nOut, pOut} == '0, "R1", "range reject outputs", {kOut, nOut, pOut}, 0);

    // R6: in range but no candidate, full-length search
    runSearch(24'd2048128, -1, '0, lat);
    check(lat == LAT_OK, "R6", "no-candidate latency", lat, LAT_OK);
    check(err == 1, "R6", "no-candidate err", err, 1);

    // boundary: l equals base*31 exactly
    runSearch(24'd1984124, -1, '0, lat);
    check(kOut == 31 && nOut == 1 && err == 0, "R4", "k=31 n=1 boundary",
          {kOut, nOut}, {5'd31, 7'd1});

    // R5: l equals base, remainders zero for k=1 and k=2, first wins
    runSearch(24'd64004, -1, '0, lat);
    check(kOut == 1, "R5", "tie keeps first k", kOut, 1);
    check(nOut == 1, "R5", "tie keeps first n", nOut, 1);

    // R2: clamped period matches 5000
    runSearch(24'd5000, -1, '0, lat);
    {e5, k5, n5, p5} = {err, kOut, nOut, pOut};
    runSearch(24'd1, -1, '0, lat);
    check({err, kOut, nOut, pOut} == {e5, k5, n5, p5}, "R2", "clamp equals 5000",
          {err, kOut, nOut, pOut}, {e5, k5, n5, p5});
    check(lat == LAT_OK, "R2", "clamp latency", lat, LAT_OK);

    // R8: start mid-search is ignored
    runSearch(24'd39721, 100, 24'd9000000, lat);
    checkResult(24'd39721, "R8 ignored start", lat);

    // R9: outputs hold while idle
    {e5, k5, n5, p5} = {err, kOut, nOut, pOut};
    repeat (20) @(negedge clk);
    check({err, kOut, nOut, pOut} == {e5, k5, n5, p5}, "R9", "outputs hold idle",
          {err, kOut, nOut, pOut}, {e5, k5, n5, p5});
    check(done == 1, "R7", "done held idle", done, 1);

    // R9: outputs hold during the next search until done rises
    @(negedge clk);
    start = 1'b1;
    periodPs = 24'd16001;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    check({err, kOut, nOut, pOut} == {e5, k5, n5, p5}, "R9", "outputs hold during run",
          {err, kOut, nOut, pOut}, {e5, k5, n5, p5});
    while (!done) @(negedge clk);
    checkResult(24'd16001, "R9 after run", LAT_OK);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule